// File: doc/BRIEF.md
# Fractional-Correction Tick Generator

This block turns a fast system clock into a one-cycle clock-enable pulse whose average period is a whole number of input cycles plus a fraction in sixteenths. The whole part comes from a small count field. The fraction comes from a 4-bit correction index, which sits in the upper half of a separate correction field. A fraction accumulator adds the index once per output period. Each time the accumulator carries out, that period is lengthened by one input cycle, so over sixteen periods exactly `index` extra cycles are inserted.

The same block serves two places on a serial infrared link, chosen by parameters. In the reference-tick form (`SCALE = 1`, `ALLOW_ZERO = 0`), the whole part of the period is `count + 1` cycles, and a count of zero is illegal. In the oversampled serial form (`SCALE = 16`, `ALLOW_ZERO = 1`), one bit spans `(count + 1) × 16` cycles plus the correction, and every count value is legal. New field values are picked up only at a period boundary. An illegal zero count stops the tick and raises a flag that stays set.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, `tick` and `zero_cnt_err` are both low.
- R2: `tick` is high for exactly one cycle per period whenever the shortest legal period is two or more cycles.
- R3: Each period lasts `(div_cnt + 1) × SCALE` cycles, or one cycle more. Over any 16 consecutive periods with fixed fields, the total extra cycles equal the fraction index.
- R4: The accumulator starts at zero when the block is enabled. Period k (k = 1 is the first after enabling) is lengthened exactly when floor(k·f/16) > floor((k−1)·f/16), where f is the fraction index.
- R5: The fraction index is taken from bits [2·FRAC_W−1:FRAC_W] of `corr_reg`, which is bits 7:4 at the defaults. The low FRAC_W bits have no effect on any period.
- R6: Fields are sampled only at a period boundary. A period already under way when new values are written finishes with its old length, and the following period uses the new values.
- R7: While `en` is low, no tick is produced and the accumulator is cleared. After `en` rises, the first tick comes one full period after the first enabled clock edge.
- R8: With `ALLOW_ZERO = 0`, a zero `div_cnt` seen at a boundary stops the divider with no further ticks and sets `zero_cnt_err`. A period already under way still ends with its tick.
- R9: `zero_cnt_err` stays set until reset. Ticking resumes as soon as a nonzero count is present, with no other action needed.
- R10: With `ALLOW_ZERO = 1` and `SCALE = 16`, a zero count is legal and gives 16-cycle periods plus the correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears the divider and accumulator |
| div_cnt | input | CNT_W | Whole-period count field (divisor minus one) |
| corr_reg | input | 2*FRAC_W | Correction field; the fraction index is in the upper half |
| tick | output | 1 | One-cycle enable pulse, one per period |
| zero_cnt_err | output | 1 | Sticky flag: an illegal zero count was seen |

## Verification
The bench builds two instances side by side. One uses `SCALE = 1, ALLOW_ZERO = 0`, which exercises the illegal-zero halt, the sticky flag and periods as short as two cycles. The other uses `SCALE = 16, ALLOW_ZERO = 1`, which exercises the scaled period up to 257 cycles and the legal zero count. With both, every one of the sixteen fraction indices can be checked exactly, period by period, against the carry pattern, alongside random junk in the ignored low correction bits.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/ftg_frac_acc.sv
module ftg_frac_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_s;

    acc_s            st_q, st_d;
    logic [FRAC_W:0] sum;

    always_comb begin
        sum   = {1'b0, st_q.acc} + {1'b0, frac};
        carry = sum[FRAC_W];
        st_d  = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (step) begin
            st_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ftg_divider.sv
module ftg_divider
    import ftg_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load_ok,
    input  logic [LEN_W-1:0] load_len,
    output logic             boundary,
    output logic             tick
);
    typedef struct packed {
        div_state_e       st;
        logic [LEN_W-1:0] cnt;
        logic             tick;
    } div_s;

    div_s st_q, st_d;

    always_comb begin
        boundary = (st_q.st == DIV_IDLE) || (st_q.cnt == '0);
        st_d     = st_q;
        st_d.tick = 1'b0;
        if (!en) begin
            st_d.st  = DIV_IDLE;
            st_d.cnt = '0;
        end else if (boundary) begin
            st_d.tick = (st_q.st == DIV_RUN);
            if (load_ok) begin
                st_d.st  = DIV_RUN;
                st_d.cnt = load_len - LEN_W'(1);
            end else begin
                st_d.st  = DIV_IDLE;
                st_d.cnt = '0;
            end
        end else begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: DIV_IDLE, cnt: '0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
    parameter int CNT_W      = 4,
    parameter int FRAC_W     = 4,
    parameter int SCALE      = 1,
    parameter bit ALLOW_ZERO = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [CNT_W-1:0]    div_cnt,
    input  logic [2*FRAC_W-1:0] corr_reg,
    output logic                tick,
    output logic                zero_cnt_err
);
    localparam int MAX_LEN = (1 << CNT_W) * SCALE + 1;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic err;
    } top_s;

    top_s              st_q, st_d;
    logic [FRAC_W-1:0] frac_idx;
    logic              cnt_legal;
    logic              boundary;
    logic              carry;
    logic              step;
    logic [LEN_W-1:0]  len;

    assign frac_idx  = corr_reg[2*FRAC_W-1:FRAC_W];
    assign cnt_legal = ALLOW_ZERO || (div_cnt != '0);
    assign step      = en && boundary && cnt_legal;
    assign len       = (LEN_W'(div_cnt) + LEN_W'(1)) * LEN_W'(SCALE) + LEN_W'(carry);

    ftg_frac_acc #(.FRAC_W(FRAC_W)) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .step  (step),
        .frac  (frac_idx),
        .carry (carry)
    );

    ftg_divider #(.LEN_W(LEN_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load_ok  (cnt_legal),
        .load_len (len),
        .boundary (boundary),
        .tick     (tick)
    );

    always_comb begin
        st_d = st_q;
        if (en && boundary && !cnt_legal) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign zero_cnt_err = st_q.err;
endmodule

// File: rtl/ftg_chk.sv
module ftg_chk #(
    parameter int CNT_W      = 4,
    parameter int SCALE      = 1,
    parameter bit ALLOW_ZERO = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] div_cnt,
    input logic             tick,
    input logic             zero_cnt_err
);
    generate
        if (SCALE >= 2 || !ALLOW_ZERO) begin : g_pulse
            // R2
            tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
        if (!ALLOW_ZERO) begin : g_zero
            // R8
            err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(zero_cnt_err) |-> ($past(div_cnt) == '0) && $past(en));
        end else begin : g_nozero
            // R10
            zero_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !zero_cnt_err);
        end
    endgenerate

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cnt_err |=> zero_cnt_err);
endmodule

bind frac_tick_gen ftg_chk #(
    .CNT_W      (CNT_W),
    .SCALE      (SCALE),
    .ALLOW_ZERO (ALLOW_ZERO)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .div_cnt      (div_cnt),
    .tick         (tick),
    .zero_cnt_err (zero_cnt_err)
);

// File: tb/frac_tick_gen_tb_top.sv
`timescale 1ns/1ps
module frac_tick_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_en = 1'b0, ua_en = 1'b0;
    logic [3:0] ir_cnt = 4'd1, ua_cnt = 4'd0;
    logic [7:0] ir_corr = 8'h00, ua_corr = 8'h00;
    logic       ir_tick, ua_tick, ir_err, ua_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frac_tick_gen #(.SCALE(1), .ALLOW_ZERO(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(ir_en), .div_cnt(ir_cnt),
        .corr_reg(ir_corr), .tick(ir_tick), .zero_cnt_err(ir_err)
    );

    frac_tick_gen #(.SCALE(16), .ALLOW_ZERO(1'b1)) uart_i (
        .clk(clk), .rst_n(rst_n), .en(ua_en), .div_cnt(ua_cnt),
        .corr_reg(ua_corr), .tick(ua_tick), .zero_cnt_err(ua_err)
    );

    function automatic int exp_len(int base, int f, int k);
        return base + ((k * f) / 16 - ((k - 1) * f) / 16);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input bit uart, output int gap);
        bit seen;
        gap = 0;
        seen = 1'b0;
        while (!seen && gap < 3000) begin
            @(negedge clk);
            gap++;
            seen = uart ? ua_tick : ir_tick;
        end
    endtask

    task automatic quiet(input bit uart, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (uart ? ua_tick : ir_tick) hits++;
        end
    endtask

    task automatic trial(input bit uart, input logic [3:0] c, input logic [7:0] corr);
        int base, f, gap, sum, bad, first_bad_act, first_bad_exp, pulse_w;
        @(negedge clk);
        if (uart) ua_en = 1'b0; else ir_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (uart) begin ua_cnt = c; ua_corr = corr; ua_en = 1'b1; end
        else begin ir_cnt = c; ir_corr = corr; ir_en = 1'b1; end
        base = (int'(c) + 1) * (uart ? 16 : 1);
        f = int'(corr[7:4]);
        wait_tick(uart, gap);
        // R7: first tick one full period after the first enabled edge
        chk(gap == exp_len(base, f, 1) + 1, "R7 first tick", gap, exp_len(base, f, 1) + 1);
        sum = 0; bad = 0; first_bad_act = 0; first_bad_exp = 0; pulse_w = 0;
        for (int k = 2; k <= 17; k++) begin
            wait_tick(uart, gap);
            sum += gap;
            if (gap != exp_len(base, f, k)) begin
                if (bad == 0) begin first_bad_act = gap; first_bad_exp = exp_len(base, f, k); end
                bad++;
            end
        end
        // R4, R5: exact stretch pattern, low correction bits are random junk
        chk(bad == 0, "R4/R5 period pattern", first_bad_act, first_bad_exp);
        // R3: sixteen periods carry exactly f extra cycles
        chk(sum == 16 * base + f, "R3 sixteen-period sum", sum, 16 * base + f);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int gap, hits;
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        // R1
        chk(ir_tick == 1'b0 && ua_tick == 1'b0, "R1 tick low in reset", ir_tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ir_err == 1'b0 && ua_err == 1'b0, "R1 flag low after reset", ir_err, 0);

        // R2: shortest legal reference period, pulses must separate
        ir_cnt = 4'd1; ir_corr = 8'h00; ir_en = 1'b1;
        wait_tick(1'b0, gap);
        @(negedge clk);
        chk(ir_tick == 1'b0, "R2 tick one cycle wide", ir_tick, 0);
        wait_tick(1'b0, gap);
        chk(gap == 1, "R2 next tick after 2-cycle period", gap + 1, 2);

        // R6: change after a tick; old period completes first
        ir_cnt = 4'd5;
        wait_tick(1'b0, gap);
        chk(gap == 2, "R6 old length finishes", gap, 2);
        wait_tick(1'b0, gap);
        chk(gap == 6, "R6 new length used next", gap, 6);

        // R8: zero programmed mid-run
        ir_cnt = 4'd3;
        wait_tick(1'b0, gap);
        wait_tick(1'b0, gap);
        chk(ir_err == 1'b0, "R8 flag clear before zero", ir_err, 0);
        ir_cnt = 4'd0;
        wait_tick(1'b0, gap);
        chk(gap == 4, "R8 running period ends with tick", gap, 4);
        chk(ir_err == 1'b1, "R8 flag set", ir_err, 1);
        quiet(1'b0, 40, hits);
        chk(hits == 0, "R8 divider halted", hits, 0);

        // R9: sticky flag and resume
        ir_cnt = 4'd2;
        wait_tick(1'b0, gap);
        chk(gap == 4, "R9 resume after nonzero count", gap, 4);
        wait_tick(1'b0, gap);
        chk(gap == 3, "R9 resumed period length", gap, 3);
        chk(ir_err == 1'b1, "R9 flag stays set", ir_err, 1);

        // R7: disabled means no ticks
        @(negedge clk);
        ir_en = 1'b0;
        quiet(1'b0, 50, hits);
        chk(hits == 0, "R7 no tick while disabled", hits, 0);

        // R10: zero count legal in the oversampled form
        trial(1'b1, 4'd0, 8'h5A);
        chk(ua_err == 1'b0, "R10 no flag on zero count", ua_err, 0);

        // Directed fraction corners and random sweeps
        trial(1'b0, 4'd1, 8'hF3);
        trial(1'b0, 4'd15, 8'h8C);
        trial(1'b1, 4'd15, 8'hFF);
        for (int t = 0; t < 20; t++) begin
            logic [3:0] c;
            c = 4'($urandom_range(1, 15));
            trial(1'b0, c, 8'($urandom_range(0, 255)));
        end
        for (int t = 0; t < 6; t++) begin
            trial(1'b1, 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)));
        end

        // R9: only reset clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ir_err == 1'b0, "R9 flag cleared by reset", ir_err, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule